// File: doc/BRIEF.md
# Windowed System Bus Splitter

This block fans one simple memory-mapped master out to eight slave ports. The master issues single-word accesses. Each access has an address, write data, a four-bit byte-lane select and a one-cycle write or read strobe. The block finds which of eight 1 MiB windows the address lands in. It passes the strobe to that slave alone and routes that slave's read data, error and acknowledge back to the master.

The eight windows sit back to back from 0x4000_0000. The window index comes from address bits [22:20]. An address whose upper bits [31:23] are not the base prefix selects nothing, and the block answers it itself with an error.

The block remembers which slave was addressed by the last strobe. Slaves that take several cycles to acknowledge are therefore heard from the right port. A parameter can retire any port, and a retired port answers at once with zero data and no error. All slave read data arrives packed in one flat vector, with slave n in bits [n*32 +: 32].

Top module: `bus_window_split`

## Requirements
- R1: A strobe to an address with bits [31:23] equal to 9'h080 raises only the enable of the port numbered by bits [22:20], in the same cycle as the strobe.
- R2: A strobe to an address with any other bits [31:23] raises no slave enable. From that cycle until the next strobe, the master sees acknowledge 1, error 1 and read data 0.
- R3: In a strobe cycle to an active port n, the master read data, error and acknowledge equal that port's word sRdata[n*32 +: 32], sErr[n] and sAck[n].
- R4: Between strobes, the master response keeps coming from the port chosen by the last strobe. Acknowledges and errors from every other port have no effect on the master outputs.
- R5: A port whose bit is set in UNUSED_MASK (default 8'hA0, ports 5 and 7) never gets an enable. While selected, it answers with acknowledge 1, error 0 and data 0, whatever its inputs carry.
- R6: Address, write data and byte select reach the slave side unchanged, including address bits [1:0]. Bits [1:0] and [19:2] play no part in port selection.
- R7: Reset is active-low and synchronous. While it is low no slave enable is raised. After it, the held selection is port 0.
- R8: The write strobe only drives slave write enables, and the read strobe only drives slave read enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| mAddr | input | 32 | Master byte address |
| mWdata | input | 32 | Master write data |
| mSel | input | 4 | Master byte-lane select |
| mWen | input | 1 | Master write strobe, one cycle |
| mRen | input | 1 | Master read strobe, one cycle |
| mRdata | output | 32 | Read data returned to master |
| mErr | output | 1 | Error returned to master |
| mAck | output | 1 | Acknowledge returned to master |
| sAddr | output | 32 | Address broadcast to all slaves |
| sWdata | output | 32 | Write data broadcast to all slaves |
| sSel | output | 4 | Byte select broadcast to all slaves |
| sWen | output | 8 | Per-slave write enable |
| sRen | output | 8 | Per-slave read enable |
| sRdata | input | 256 | Flat slave read data, slave n at [n*32 +: 32] |
| sErr | input | 8 | Per-slave error |
| sAck | input | 8 | Per-slave acknowledge |

## Verification
A corrupted held selection shows up in the first idle cycle after a strobe. From then on the master acknowledge, error and data follow the wrong port. With slave responses randomised every cycle, the error surfaces within a cycle or two. A wrong decode shows in the strobe cycle itself as an enable on the wrong port or a missing error on an out-of-range address. Both are compared against a behavioural model on every clock.

// File: rtl/bus_window_pkg.sv
package bus_window_pkg;
  localparam int PORT_N = 8;
  localparam int IDX_W  = $clog2(PORT_N);

  // Strobes and selection handed from control to datapath
  typedef struct packed {
    logic [PORT_N-1:0] wen;
    logic [PORT_N-1:0] ren;
    logic [IDX_W-1:0]  idx;
    logic              miss;
  } winCtl_t;
endpackage

// File: rtl/bus_window_ctrl.sv
module bus_window_ctrl
  import bus_window_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_LSB = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000,
  localparam int HI_W = ADDR_W - WIN_LSB,
  localparam int PREFIX_LSB = WIN_LSB + IDX_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [HI_W-1:0] winAddr,
  input  logic            mWen,
  input  logic            mRen,
  output winCtl_t         ctl
);
  logic [IDX_W-1:0] decIdx;
  logic             decHit;
  logic             strobe;
  logic [IDX_W-1:0] heldIdx;
  logic             heldMiss;

  always_comb begin
    decIdx = winAddr[IDX_W-1:0];
    decHit = (winAddr[HI_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:PREFIX_LSB]);
    strobe = mWen | mRen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldIdx  <= '0;
      heldMiss <= 1'b0;
    end else if (strobe) begin
      heldIdx  <= decIdx;
      heldMiss <= !decHit;
    end
  end

  always_comb begin
    ctl.wen  = '0;
    ctl.ren  = '0;
    ctl.idx  = strobe ? decIdx : heldIdx;
    ctl.miss = strobe ? !decHit : heldMiss;
    if (rstN && decHit) begin
      ctl.wen[decIdx] = mWen;
      ctl.ren[decIdx] = mRen;
    end
  end
endmodule

// File: rtl/bus_window_dp.sv
module bus_window_dp
  import bus_window_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [PORT_N-1:0] UNUSED_MASK = 8'hA0
) (
  input  winCtl_t                    ctl,
  input  logic [PORT_N*DATA_W-1:0]   sRdataIn,
  input  logic [PORT_N-1:0]          sErrIn,
  input  logic [PORT_N-1:0]          sAckIn,
  output logic [PORT_N-1:0]          sWen,
  output logic [PORT_N-1:0]          sRen,
  output logic [DATA_W-1:0]          mRdata,
  output logic                       mErr,
  output logic                       mAck
);
  logic [DATA_W-1:0] effData [PORT_N];
  logic [PORT_N-1:0] effErr;
  logic [PORT_N-1:0] effAck;

  // Retired ports answer with a fixed reply and never see a strobe
  for (genvar g = 0; g < PORT_N; g++) begin : g_port
    always_comb begin
      sWen[g]    = UNUSED_MASK[g] ? 1'b0 : ctl.wen[g];
      sRen[g]    = UNUSED_MASK[g] ? 1'b0 : ctl.ren[g];
      effData[g] = UNUSED_MASK[g] ? '0 : sRdataIn[g*DATA_W +: DATA_W];
      effErr[g]  = UNUSED_MASK[g] ? 1'b0 : sErrIn[g];
      effAck[g]  = UNUSED_MASK[g] ? 1'b1 : sAckIn[g];
    end
  end

  always_comb begin
    if (ctl.miss) begin
      mRdata = '0;
      mErr   = 1'b1;
      mAck   = 1'b1;
    end else begin
      mRdata = effData[ctl.idx];
      mErr   = effErr[ctl.idx];
      mAck   = effAck[ctl.idx];
    end
  end
endmodule

// File: rtl/bus_window_split.sv
module bus_window_split
  import bus_window_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_LSB = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000,
  parameter logic [PORT_N-1:0] UNUSED_MASK = 8'hA0,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         mAddr,
  input  logic [DATA_W-1:0]         mWdata,
  input  logic [SEL_W-1:0]          mSel,
  input  logic                      mWen,
  input  logic                      mRen,
  output logic [DATA_W-1:0]         mRdata,
  output logic                      mErr,
  output logic                      mAck,
  output logic [ADDR_W-1:0]         sAddr,
  output logic [DATA_W-1:0]         sWdata,
  output logic [SEL_W-1:0]          sSel,
  output logic [PORT_N-1:0]         sWen,
  output logic [PORT_N-1:0]         sRen,
  input  logic [PORT_N*DATA_W-1:0]  sRdata,
  input  logic [PORT_N-1:0]         sErr,
  input  logic [PORT_N-1:0]         sAck
);
  winCtl_t ctl;

  assign sAddr  = mAddr;
  assign sWdata = mWdata;
  assign sSel   = mSel;

  bus_window_ctrl #(
    .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .winAddr(mAddr[ADDR_W-1:WIN_LSB]),
    .mWen(mWen), .mRen(mRen), .ctl(ctl)
  );

  bus_window_dp #(
    .DATA_W(DATA_W), .UNUSED_MASK(UNUSED_MASK)
  ) u_dp (
    .ctl(ctl), .sRdataIn(sRdata), .sErrIn(sErr), .sAckIn(sAck),
    .sWen(sWen), .sRen(sRen), .mRdata(mRdata), .mErr(mErr), .mAck(mAck)
  );
endmodule

// File: rtl/bus_window_split_chk.sv
module bus_window_split_chk #(
  parameter logic [7:0] UNUSED_MASK = 8'hA0
) (
  input logic         clk,
  input logic         rstN,
  input logic [31:0]  mAddr,
  input logic         mWen,
  input logic         mRen,
  input logic [31:0]  mRdata,
  input logic         mErr,
  input logic         mAck,
  input logic [7:0]   sWen,
  input logic [7:0]   sRen,
  input logic [255:0] sRdata,
  input logic [7:0]   sAck
);
  logic strobe, hit;
  logic [2:0] idx;
  assign strobe = mWen | mRen;
  assign hit    = (mAddr[31:23] == 9'h080);
  assign idx    = mAddr[22:20];

  assert_enable_onehot_R1: assert property (@(posedge clk)
    $onehot0(sWen | sRen));

  assert_miss_answer_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && !hit) |-> (mAck && mErr && mRdata == '0 && sWen == '0 && sRen == '0));

  assert_read_route_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mRen && hit && !UNUSED_MASK[idx]) |-> (mRdata == sRdata[idx*32 +: 32]));

  assert_held_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe && $past(rstN) && $past(strobe) && $past(hit) && !UNUSED_MASK[$past(idx)])
      |-> (mAck == sAck[$past(idx)]));

  assert_unused_quiet_R5: assert property (@(posedge clk)
    ((sWen & UNUSED_MASK) == '0) && ((sRen & UNUSED_MASK) == '0));

  assert_reset_noen_R7: assert property (@(posedge clk)
    !rstN |-> (sWen == '0 && sRen == '0));

  assert_dir_wen_R8: assert property (@(posedge clk)
    (sWen != '0) |-> mWen);

  assert_dir_ren_R8: assert property (@(posedge clk)
    (sRen != '0) |-> mRen);
endmodule

bind bus_window_split bus_window_split_chk #(.UNUSED_MASK(UNUSED_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .mAddr(mAddr), .mWen(mWen), .mRen(mRen),
  .mRdata(mRdata), .mErr(mErr), .mAck(mAck), .sWen(sWen), .sRen(sRen),
  .sRdata(sRdata), .sAck(sAck)
);

// File: tb/bus_window_split_bench.sv
`timescale 1ns/1ps
module bus_window_split_bench;
  localparam logic [7:0] UNUSED = 8'hA0;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rstN = 1'b0;
  logic [31:0]  mAddr = '0, mWdata = '0;
  logic [3:0]   mSel = '0;
  logic         mWen = 1'b0, mRen = 1'b0;
  logic [31:0]  mRdata;
  logic         mErr, mAck;
  logic [31:0]  sAddr, sWdata;
  logic [3:0]   sSel;
  logic [7:0]   sWen, sRen;
  logic [255:0] sRdata = '0;
  logic [7:0]   sErr = '0, sAck = '0;

  bus_window_split u_bus_window_split (
    .clk(clk), .rstN(rstN), .mAddr(mAddr), .mWdata(mWdata), .mSel(mSel),
    .mWen(mWen), .mRen(mRen), .mRdata(mRdata), .mErr(mErr), .mAck(mAck),
    .sAddr(sAddr), .sWdata(sWdata), .sSel(sSel), .sWen(sWen), .sRen(sRen),
    .sRdata(sRdata), .sErr(sErr), .sAck(sAck)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // Reference model state: port picked by the last strobe
  int heldIdx = 0;
  bit heldMiss = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      heldIdx = 0; heldMiss = 0;
    end else if (mWen || mRen) begin
      heldIdx = mAddr[22:20];
      heldMiss = (mAddr[31:23] != 9'h080);
    end
  end

  // Slave replies change every cycle
  always @(posedge clk) begin
    #1;
    for (int n = 0; n < 8; n++) sRdata[n*32 +: 32] = $urandom;
    sAck = $urandom;
    sErr = $urandom;
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      bit strobe, hit, selMiss;
      int idx, selIdx;
      logic [7:0] expWen, expRen;
      logic [31:0] expData;
      logic expErr, expAck;
      string enTag, rspTag;
      strobe = mWen || mRen;
      hit = (mAddr[31:23] == 9'h080);
      idx = mAddr[22:20];
      selIdx = strobe ? idx : heldIdx;
      selMiss = strobe ? !hit : heldMiss;
      expWen = '0; expRen = '0;
      if (rstN && hit && !UNUSED[idx]) begin
        expWen[idx] = mWen;
        expRen[idx] = mRen;
      end
      if (selMiss) begin
        expData = '0; expErr = 1; expAck = 1;
      end else if (UNUSED[selIdx]) begin
        expData = '0; expErr = 0; expAck = 1;
      end else begin
        expData = sRdata[selIdx*32 +: 32]; expErr = sErr[selIdx]; expAck = sAck[selIdx];
      end
      if (!rstN) enTag = "R7";
      else if (strobe && !hit) enTag = "R2";
      else if (strobe && UNUSED[idx]) enTag = "R5";
      else enTag = "R1 R8";
      if (selMiss) rspTag = "R2";
      else if (UNUSED[selIdx]) rspTag = "R5";
      else if (strobe) rspTag = "R3";
      else rspTag = "R4";
      chk(enTag, "sWen", {24'h0, sWen}, {24'h0, expWen});
      chk(enTag, "sRen", {24'h0, sRen}, {24'h0, expRen});
      chk(rspTag, "mRdata", mRdata, expData);
      chk(rspTag, "mErr", {31'h0, mErr}, {31'h0, expErr});
      chk(rspTag, "mAck", {31'h0, mAck}, {31'h0, expAck});
      chk("R6", "sAddr", sAddr, mAddr);
      chk("R6", "sWdata", sWdata, mWdata);
      chk("R6", "sSel", {28'h0, sSel}, {28'h0, mSel});
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic access(logic [31:0] addr, bit w, bit r, int idle);
    @(posedge clk); #1;
    mAddr = addr; mWen = w; mRen = r;
    mWdata = $urandom; mSel = $urandom;
    @(posedge clk); #1;
    mWen = 0; mRen = 0;
    for (int k = 0; k < idle; k++) @(posedge clk);
  endtask

  initial begin
    // R7: strobes during reset must not reach any slave
    @(posedge clk); #1;
    mAddr = 32'h4020_0010; mWen = 1;
    repeat (3) @(posedge clk);
    #1; mWen = 0; mRen = 1;
    @(posedge clk); #1;
    mRen = 0; rstN = 1;
    repeat (3) @(posedge clk);
    // R1 R3 R6: every window, nonzero low address bits
    for (int n = 0; n < 8; n++) begin
      access(32'h4000_0000 | (n << 20) | 32'h0001_2343, 1, 0, 2);
      access(32'h4000_0000 | (n << 20) | 32'h000F_FFFD, 0, 1, 3);
    end
    // R2: addresses outside the windows
    access(32'h3FFF_FFFC, 0, 1, 3);
    access(32'h4080_0000, 1, 0, 3);
    access(32'hC000_0000, 0, 1, 2);
    // R4: back-to-back strobes then long holds
    access(32'h4010_0000, 0, 1, 0);
    access(32'h4060_0000, 0, 1, 6);
    access(32'h4070_0000, 1, 0, 4);
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom % 4 != 0) a[31:23] = 9'h080;
      access(a, ($urandom % 2) == 1, ($urandom % 3) == 0, $urandom % 4);
    end
    repeat (3) @(posedge clk);
    report();
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule